// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a running calendar (seconds, minutes, hours, day of month and weekday, all in BCD) and raises an alarm when the calendar matches a programmed 32-bit alarm word. Each of the four fields in the word has its own don't-care bit. A masked field takes no part in the comparison, so an alarm can fire every minute, every hour or every day. The day field is read either as a BCD day of month or as a weekday code, depending on a selector bit.

The match sets a sticky alarm flag once per match event. The flag drives an interrupt line when the interrupt enable is high. Software clears the flag with a write whose polarity is chosen by a parameter. The alarm word can only be changed while the alarm is disabled. After the enable drops, a write-allowed status rises a fixed number of cycles later, and only then is a write to the word accepted. The calendar counters are outside this block and feed it.

Top module: `alarm_comparator`

## Requirements
- R1: Seconds are compared against word bits [6:0] and minutes against bits [14:8], as BCD values. A field differing by one unit produces no match.
- R2: A field whose don't-care bit is 1 (bit 7 seconds, bit 15 minutes, bit 23 hours, bit 31 day) is left out of the match. With the day masked, the alarm fires on any day.
- R3: With bit 30 at 1, word bits [27:24] hold a weekday code (1 Monday to 7 Sunday) compared against `cur_wday`, and code 0 never matches. With bit 30 at 0, bits [29:24] hold a BCD day of month compared against `cur_date`.
- R4: Hours are compared against bits [21:16]. The PM bit 22 is compared with `cur_pm` only when `fmt_12h` is 1 and is ignored when it is 0.
- R5: While `alm_en` is 1, the flag is set on the clock edge where the full match first becomes true. It is not set again while the match stays true after a clear. No flag is ever set while `alm_en` is 0.
- R6: `alarm_irq` is high exactly when the flag is set and `alm_ie` is 1.
- R7: With `CLR_BY_ONE` = 0 (default), a clear write with `flag_clr_val` = 0 clears the flag and one with value 1 has no effect. With `CLR_BY_ONE` = 1 the polarity is reversed. A new match on the same edge as a clear wins.
- R8: `wr_allowed` is 0 whenever `alm_en` is 1. It rises after `SYNC_CYCLES` (default 2) clock edges with `alm_en` held at 0.
- R9: A write to the alarm word takes effect only when `wr_allowed` is 1. Otherwise the word, readable on `alarm_word`, is unchanged.
- R10: After reset the flag and interrupt are 0, the alarm word is 0, and `wr_allowed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current PM indicator (12-hour mode) |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 1 Monday to 7 Sunday |
| fmt_12h | input | 1 | 1 selects 12-hour comparison of the PM bit |
| alm_en | input | 1 | Alarm enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| word_wr | input | 1 | Write strobe for the alarm word |
| word_wdata | input | 32 | New alarm word |
| flag_clr_wr | input | 1 | Flag clear write strobe |
| flag_clr_val | input | 1 | Data bit of the clear write |
| alarm_word | output | 32 | Current alarm word |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |
| wr_allowed | output | 1 | Alarm word may be written |

## Verification
The match is exercised with near misses one BCD unit away from the target and with exact hits. Masked fields are set far from their targets, which separates "excluded" from "compared". The day selector is tried with a weekday code whose value also equals the current date, with the invalid weekday code 0, and with a BCD date. This shows the two interpretations of the shared bits are kept apart. The PM bit is toggled in both hour formats. Clears are issued with both data polarities and while the match persists, which distinguishes edge-triggered from level-triggered setting. Writes are attempted both during and after the enable-to-write-allowed wait.

// File: rtl/alarm_pkg.sv
// Package: alarm_pkg
// Field positions and widths of the alarm word. Only positions the match
// logic decodes are listed; every module takes them from here.
package alarm_pkg;
    localparam int WORD_W    = 32;
    localparam int SEC_LSB   = 0;
    localparam int SEC_W     = 7;
    localparam int SEC_DC    = 7;
    localparam int MIN_LSB   = 8;
    localparam int MIN_W     = 7;
    localparam int MIN_DC    = 15;
    localparam int HOUR_LSB  = 16;
    localparam int HOUR_W    = 6;
    localparam int PM_BIT    = 22;
    localparam int HOUR_DC   = 23;
    localparam int DAY_LSB   = 24;
    localparam int DATE_W    = 6;
    localparam int WDAY_W    = 4;
    localparam int DAY_SEL   = 30;
    localparam int DAY_DC    = 31;
    localparam int CUR_WDAY_W = 3;
endpackage

// File: rtl/alarm_field_match.sv
// Module: alarm_field_match
// Compares one BCD field of the calendar against its target value.
// A set don't-care bit forces a hit. Purely combinational; assumes both
// operands use the same encoding and width.
module alarm_field_match #(
    parameter int W = 7
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] tgt_val,
    input  logic         dont_care,
    output logic         hit
);
    // Hit when masked or equal.
    always_comb begin
        hit = dont_care | (cur_val == tgt_val);
    end
endmodule

// File: rtl/alarm_day_match.sv
// Module: alarm_day_match
// Decodes the shared day field as weekday code or BCD day of month
// according to the selector. Weekday code 0 is invalid and never hits.
// Assumes the weekday input uses 1..7 coding.
module alarm_day_match
    import alarm_pkg::*;
(
    input  logic [DATE_W-1:0]     cur_date,
    input  logic [CUR_WDAY_W-1:0] cur_wday,
    input  logic [DATE_W-1:0]     day_field,
    input  logic                  use_wday,
    input  logic                  dont_care,
    output logic                  hit
);
    logic [WDAY_W-1:0] wday_code;
    logic              wday_hit;
    logic              date_hit;

    // Extract weekday code from the low bits of the day field.
    always_comb begin
        wday_code = day_field[WDAY_W-1:0];
    end

    // Weekday comparison, rejecting the invalid code.
    always_comb begin
        wday_hit = (wday_code != '0) &&
                   (wday_code == {{(WDAY_W-CUR_WDAY_W){1'b0}}, cur_wday});
    end

    // Day-of-month comparison on the full BCD field.
    always_comb begin
        date_hit = (day_field == cur_date);
    end

    // Select interpretation and apply don't-care.
    always_comb begin
        hit = dont_care | (use_wday ? wday_hit : date_hit);
    end
endmodule

// File: rtl/alarm_wr_gate.sv
// Module: alarm_wr_gate
// Generates the write-allowed status: counts clock edges with the alarm
// disabled and reports permission once SYNC_CYCLES have elapsed. Any
// cycle with the enable high restarts the wait and blocks writes at once.
module alarm_wr_gate #(
    parameter int SYNC_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alm_en,
    output logic wr_ok
);
    localparam int CW = $clog2(SYNC_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SYNC_CYCLES);

    logic [CW-1:0] wait_cnt;

    // Count disabled cycles up to the limit; restart while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (alm_en) begin
            wait_cnt <= '0;
        end else if (wait_cnt != LIMIT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Permission only after the wait and never while enabled.
    always_comb begin
        wr_ok = (wait_cnt == LIMIT) && !alm_en;
    end
endmodule

// File: rtl/alarm_flag_ctrl.sv
// Module: alarm_flag_ctrl
// Holds the sticky alarm flag. Sets it on the rising edge of the
// qualified match and clears it on a clear write of the configured
// polarity; a set on the same edge takes precedence.
module alarm_flag_ctrl #(
    parameter bit CLR_BY_ONE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match_now,
    input  logic clr_wr,
    input  logic clr_val,
    output logic flag
);
    logic match_q;
    logic match_rise;
    logic clr_hit;

    // Remember last cycle's match for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match_now;
        end
    end

    // Decode edge and clear request.
    always_comb begin
        match_rise = match_now && !match_q;
        clr_hit    = clr_wr && (clr_val == CLR_BY_ONE);
    end

    // Sticky flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match_rise) begin
            flag <= 1'b1;
        end else if (clr_hit) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/alarm_comparator.sv
// Module: alarm_comparator
// Top of the calendar alarm unit: stores the alarm word behind the write
// gate, compares each calendar field under its don't-care bit, and
// drives the sticky flag and interrupt. Assumes calendar inputs are
// valid BCD and change synchronously to clk.
module alarm_comparator
    import alarm_pkg::*;
#(
    parameter int SYNC_CYCLES = 2,
    parameter bit CLR_BY_ONE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic              cur_pm,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [CUR_WDAY_W-1:0] cur_wday,
    input  logic              fmt_12h,
    input  logic              alm_en,
    input  logic              alm_ie,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_wdata,
    input  logic              flag_clr_wr,
    input  logic              flag_clr_val,
    output logic [WORD_W-1:0] alarm_word,
    output logic              alarm_flag,
    output logic              alarm_irq,
    output logic              wr_allowed
);
    localparam int HPM_W = HOUR_W + 1;

    logic             sec_hit;
    logic             min_hit;
    logic             hour_hit;
    logic             day_hit;
    logic             full_match;
    logic [HPM_W-1:0] hour_cur;
    logic [HPM_W-1:0] hour_tgt;

    alarm_wr_gate #(.SYNC_CYCLES(SYNC_CYCLES)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .alm_en (alm_en),
        .wr_ok  (wr_allowed)
    );

    // Alarm word storage, updated only when writes are permitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_word <= '0;
        end else if (word_wr && wr_allowed) begin
            alarm_word <= word_wdata;
        end
    end

    alarm_field_match #(.W(SEC_W)) u_sec (
        .cur_val   (cur_sec),
        .tgt_val   (alarm_word[SEC_LSB +: SEC_W]),
        .dont_care (alarm_word[SEC_DC]),
        .hit       (sec_hit)
    );

    alarm_field_match #(.W(MIN_W)) u_min (
        .cur_val   (cur_min),
        .tgt_val   (alarm_word[MIN_LSB +: MIN_W]),
        .dont_care (alarm_word[MIN_DC]),
        .hit       (min_hit)
    );

    // Fold the PM bit into the hour compare only in 12-hour mode.
    always_comb begin
        hour_cur = {cur_pm & fmt_12h, cur_hour};
        hour_tgt = {alarm_word[PM_BIT] & fmt_12h,
                    alarm_word[HOUR_LSB +: HOUR_W]};
    end

    alarm_field_match #(.W(HPM_W)) u_hour (
        .cur_val   (hour_cur),
        .tgt_val   (hour_tgt),
        .dont_care (alarm_word[HOUR_DC]),
        .hit       (hour_hit)
    );

    alarm_day_match u_day (
        .cur_date  (cur_date),
        .cur_wday  (cur_wday),
        .day_field (alarm_word[DAY_LSB +: DATE_W]),
        .use_wday  (alarm_word[DAY_SEL]),
        .dont_care (alarm_word[DAY_DC]),
        .hit       (day_hit)
    );

    // Qualified match: all fields hit and the alarm is enabled.
    always_comb begin
        full_match = alm_en && sec_hit && min_hit && hour_hit && day_hit;
    end

    alarm_flag_ctrl #(.CLR_BY_ONE(CLR_BY_ONE)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_now (full_match),
        .clr_wr    (flag_clr_wr),
        .clr_val   (flag_clr_val),
        .flag      (alarm_flag)
    );

    // Interrupt gated by its enable.
    always_comb begin
        alarm_irq = alarm_flag && alm_ie;
    end
endmodule

// File: rtl/alarm_comparator_chk.sv
// Module: alarm_comparator_chk
// Port-level properties of the alarm unit, bound to every instance of
// alarm_comparator.
module alarm_comparator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        alm_en,
    input logic        alm_ie,
    input logic        word_wr,
    input logic        flag_clr_wr,
    input logic [31:0] alarm_word,
    input logic        alarm_flag,
    input logic        alarm_irq,
    input logic        wr_allowed
);
    assert_flag_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(alm_en));

    assert_flag_falls_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(flag_clr_wr));

    assert_irq_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alm_ie && alarm_flag));

    assert_no_wr_while_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alm_en |-> !wr_allowed);

    assert_wr_after_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_allowed) |-> !$past(alm_en));

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_wr || !wr_allowed) |=> $stable(alarm_word));
endmodule

bind alarm_comparator alarm_comparator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alm_en      (alm_en),
    .alm_ie      (alm_ie),
    .word_wr     (word_wr),
    .flag_clr_wr (flag_clr_wr),
    .alarm_word  (alarm_word),
    .alarm_flag  (alarm_flag),
    .alarm_irq   (alarm_irq),
    .wr_allowed  (wr_allowed)
);

// File: tb/tb_alarm_comparator.sv
module tb_alarm_comparator;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic        cur_pm = 1'b0;
    logic [5:0]  cur_date = 6'h01;
    logic [2:0]  cur_wday = 3'd1;
    logic        fmt_12h = 1'b0;
    logic        alm_en = 1'b0;
    logic        alm_ie = 1'b0;
    logic        word_wr = 1'b0;
    logic [31:0] word_wdata = '0;
    logic        flag_clr_wr = 1'b0;
    logic        flag_clr_val = 1'b0;
    logic [31:0] alarm_word;
    logic        alarm_flag;
    logic        alarm_irq;
    logic        wr_allowed;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_comparator #(.SYNC_CYCLES(SYNC), .CLR_BY_ONE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_pm(cur_pm), .cur_date(cur_date), .cur_wday(cur_wday),
        .fmt_12h(fmt_12h), .alm_en(alm_en), .alm_ie(alm_ie),
        .word_wr(word_wr), .word_wdata(word_wdata),
        .flag_clr_wr(flag_clr_wr), .flag_clr_val(flag_clr_val),
        .alarm_word(alarm_word), .alarm_flag(alarm_flag),
        .alarm_irq(alarm_irq), .wr_allowed(wr_allowed)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Disable, wait for permission, load word, enable, clear stale flag.
    task automatic arm(input logic [31:0] w);
        alm_en = 1'b0;
        tick(SYNC + 1);
        word_wr = 1'b1;
        word_wdata = w;
        tick();
        word_wr = 1'b0;
        alm_en = 1'b1;
        flag_clr_wr = 1'b1;
        flag_clr_val = 1'b0;
        tick();
        flag_clr_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", "flag after reset", alarm_flag, 0);
        check("R10", "irq after reset", alarm_irq, 0);
        check("R10", "word after reset", alarm_word, 0);
        check("R10", "wr_allowed after reset", wr_allowed, 0);
        tick();
        check("R8", "wr_allowed after 1 edge", wr_allowed, 0);
        tick();
        check("R8", "wr_allowed after 2 edges", wr_allowed, 1);
    endtask

    task automatic t_write_gate();
        alm_en = 1'b1;
        #1;
        check("R8", "wr_allowed while enabled", wr_allowed, 0);
        tick();
        word_wr = 1'b1;
        word_wdata = 32'h1234_5678;
        tick();
        word_wr = 1'b0;
        check("R9", "write while enabled ignored", alarm_word, 0);
        alm_en = 1'b0;
        word_wr = 1'b1;
        tick();
        check("R9", "write during wait ignored", alarm_word, 0);
        check("R8", "wr_allowed 1 edge after disable", wr_allowed, 0);
        word_wr = 1'b0;
        tick();
        check("R8", "wr_allowed 2 edges after disable", wr_allowed, 1);
        word_wr = 1'b1;
        tick();
        word_wr = 1'b0;
        check("R9", "write accepted", alarm_word, 32'h1234_5678);
    endtask

    task automatic t_sec_min();
        cur_sec = 7'h29; cur_min = 7'h15; cur_hour = 6'h12;
        arm(32'h8080_1530);
        tick();
        check("R1", "second off by one", alarm_flag, 0);
        cur_sec = 7'h30;
        tick();
        check("R1", "sec+min match", alarm_flag, 1);
        check("R6", "irq with ie=0", alarm_irq, 0);
        alm_ie = 1'b1;
        #1;
        check("R6", "irq with ie=1", alarm_irq, 1);
        flag_clr_wr = 1'b1; flag_clr_val = 1'b1;
        tick();
        check("R7", "clear with value 1 ignored", alarm_flag, 1);
        flag_clr_val = 1'b0;
        tick();
        flag_clr_wr = 1'b0;
        check("R7", "clear with value 0", alarm_flag, 0);
        check("R6", "irq drops with flag", alarm_irq, 0);
        tick(3);
        check("R5", "no reset while match persists", alarm_flag, 0);
        cur_sec = 7'h31;
        tick();
        cur_sec = 7'h30;
        tick();
        check("R5", "new match event sets again", alarm_flag, 1);
        cur_min = 7'h16; cur_sec = 7'h31;
        flag_clr_wr = 1'b1;
        tick();
        flag_clr_wr = 1'b0;
        cur_sec = 7'h30;
        tick();
        check("R1", "minute mismatch blocks", alarm_flag, 0);
        alm_ie = 1'b0;
    endtask

    task automatic t_mask();
        cur_sec = 7'h44; cur_min = 7'h02; cur_hour = 6'h03;
        arm(32'h8080_D945);
        tick();
        check("R2", "masked min, sec differs", alarm_flag, 0);
        cur_sec = 7'h45;
        tick();
        check("R2", "masked min/hour/day match", alarm_flag, 1);
    endtask

    task automatic t_day();
        cur_sec = 7'h00; cur_wday = 3'd2; cur_date = 6'h03;
        arm(32'h4380_8080);
        tick();
        check("R3", "weekday 2 vs code 3 (date 3 ignored)", alarm_flag, 0);
        cur_wday = 3'd3;
        tick();
        check("R3", "weekday code 3 match", alarm_flag, 1);
        cur_wday = 3'd0;
        arm(32'h4080_8080);
        tick(2);
        check("R3", "weekday code 0 never matches", alarm_flag, 0);
        cur_wday = 3'd5; cur_date = 6'h24;
        arm(32'h2580_8080);
        tick();
        check("R3", "date 24 vs 25", alarm_flag, 0);
        cur_date = 6'h25;
        tick();
        check("R3", "date 25 match", alarm_flag, 1);
    endtask

    task automatic t_pm();
        fmt_12h = 1'b0; cur_hour = 6'h06; cur_pm = 1'b0;
        arm(32'h8047_8080);
        tick();
        check("R4", "hour 06 vs 07", alarm_flag, 0);
        cur_hour = 6'h07;
        tick();
        check("R4", "24h ignores PM", alarm_flag, 1);
        fmt_12h = 1'b1;
        flag_clr_wr = 1'b1; flag_clr_val = 1'b0;
        tick();
        flag_clr_wr = 1'b0;
        tick();
        check("R4", "12h PM mismatch", alarm_flag, 0);
        cur_pm = 1'b1;
        tick();
        check("R4", "12h PM match", alarm_flag, 1);
        fmt_12h = 1'b0;
    endtask

    task automatic t_disabled();
        cur_sec = 7'h09;
        arm(32'h8080_8010);
        alm_en = 1'b0;
        cur_sec = 7'h10;
        tick(2);
        check("R5", "no flag while disabled", alarm_flag, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_write_gate();
        t_sec_min();
        t_mask();
        t_day();
        t_pm();
        t_disabled();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL all watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule